// File: doc/BRIEF.md
# Advance/Retard Code Clock Divider

This block produces the clock enable that steps a receiver's spreading-code generator. It divides a fast reference clock by a nominal ratio of 10. With a 10.24 MHz reference this gives a code rate near 1.024 MHz. A code tracking loop steers the local code phase by sending rate pulses. For one output period after each captured pulse, the divider shortens or lengthens that period by exactly one reference cycle. A shorter period advances the code; a longer one retards it. Either way the correction step is a tenth of a chip.

The direction input picks advance (divide by 9) or retard (divide by 11). A scan input forces retard whatever the direction input says. A loop that has no carrier therefore slides its code in one direction only while searching. The spacing of the rate pulses acts as the loop gain: denser pulses give faster correction. Pulses are remembered until the next period begins. Several pulses inside one period merge into a single correction. The direction in force is sampled once, at the cycle where the modified period is loaded, and holds for that whole period.

Top module: `adv_ret_clkdiv`

## Requirements
- R1: While reset is high the enable output is low. Reset is synchronous and active high. After reset is released, the enable is first high in the tenth cycle, counting the cycle that follows the last clock edge with reset high as the first.
- R2: With no rate pulses, the enable is high once every 10 reference cycles (NOM_DIV).
- R3: A correction with the advance direction (dir_adv = 1, scan = 0) makes that one period 9 cycles long. The next uncorrected period is 10 cycles again.
- R4: A correction with the retard direction (dir_adv = 0, scan = 0) makes that one period 11 cycles long. The next uncorrected period is 10 cycles again.
- R5: When scan = 1, a correction always makes an 11-cycle period, even with dir_adv = 1. Without a rate pulse the period stays 10 cycles while scan is high.
- R6: A rate pulse seen in the same cycle as the enable corrects the period that starts right after that cycle. A pulse seen in any other cycle is held and corrects the following period, not the one in progress.
- R7: Several rate pulses within one period give exactly one correction of one reference cycle.
- R8: Direction and scan are sampled in the enable cycle that starts the corrected period. Changing them later in that period has no effect on its length.
- R9: The enable is high for exactly one reference cycle per period.
- R10: A rate pulse in every period gives corrected periods back to back. For advance this means a steady 9-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_pulse | input | 1 | Correction request from the tracking loop, one or more cycles wide |
| dir_adv | input | 1 | 1 = advance (shorten period), 0 = retard (lengthen period) |
| scan | input | 1 | 1 = search mode, forces retard |
| code_en | output | 1 | One-cycle enable for the code generator, once per period |

## Verification
Every result of this block is a period length, so the bench drives inputs on falling edges and counts falling edges from one enable to the next. It starts counting at the falling edge where the enable is seen high. A rate pulse driven at that same falling edge is captured at the following rising edge, so the count returned is already the corrected length. A pulse driven at a later falling edge must leave the current count at 10 and change only the next one. The first enable after reset is due nine falling edges after the release edge, because the cycle at release already counts as the first of the period.

// File: rtl/adv_ret_clkdiv_pkg.sv
package adv_ret_clkdiv_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_ADV  = 2'd1,
        STEP_RET  = 2'd2
    } step_e;

endpackage

// File: rtl/arcd_rate_latch.sv
module arcd_rate_latch (
    input  logic clk,
    input  logic rst,
    input  logic rate_pulse,
    input  logic period_end,
    output logic corr_req
);
    typedef struct packed {
        logic pend;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (period_end) begin
            st_d.pend = 1'b0;
        end else if (rate_pulse) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a pulse arriving on the load cycle itself counts for the next period
    assign corr_req = st_q.pend | rate_pulse;
endmodule

// File: rtl/arcd_step_select.sv
module arcd_step_select
    import adv_ret_clkdiv_pkg::*;
#(
    parameter bit SCAN_FORCES_RETARD = 1'b1
) (
    input  logic  corr_req,
    input  logic  dir_adv,
    input  logic  scan,
    output step_e step
);
    logic want_adv;

    generate
        if (SCAN_FORCES_RETARD) begin : g_scan_ret
            assign want_adv = dir_adv & ~scan;
        end else begin : g_scan_ignored
            assign want_adv = dir_adv;
        end
    endgenerate

    always_comb begin
        if (!corr_req) begin
            step = STEP_NONE;
        end else if (want_adv) begin
            step = STEP_ADV;
        end else begin
            step = STEP_RET;
        end
    end
endmodule

// File: rtl/arcd_mod_counter.sv
module arcd_mod_counter
    import adv_ret_clkdiv_pkg::*;
#(
    parameter int NOM_DIV = 10
) (
    input  logic  clk,
    input  logic  rst,
    input  step_e step,
    output logic  period_end
);
    localparam int CW = $clog2(NOM_DIV + 1);
    localparam logic [CW-1:0] LOAD_ADV = CW'(NOM_DIV - 2);
    localparam logic [CW-1:0] LOAD_NOM = CW'(NOM_DIV - 1);
    localparam logic [CW-1:0] LOAD_RET = CW'(NOM_DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    assign period_end = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (period_end) begin
            unique case (step)
                STEP_ADV: st_d.cnt = LOAD_ADV;
                STEP_RET: st_d.cnt = LOAD_RET;
                default:  st_d.cnt = LOAD_NOM;
            endcase
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= LOAD_NOM;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/adv_ret_clkdiv.sv
module adv_ret_clkdiv
    import adv_ret_clkdiv_pkg::*;
#(
    parameter int NOM_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_pulse,
    input  logic dir_adv,
    input  logic scan,
    output logic code_en
);
    logic  period_end;
    logic  corr_req;
    step_e step;

    arcd_rate_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .rate_pulse (rate_pulse),
        .period_end (period_end),
        .corr_req   (corr_req)
    );

    arcd_step_select #(.SCAN_FORCES_RETARD(1'b1)) u_sel (
        .corr_req (corr_req),
        .dir_adv  (dir_adv),
        .scan     (scan),
        .step     (step)
    );

    arcd_mod_counter #(.NOM_DIV(NOM_DIV)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .period_end (period_end)
    );

    assign code_en = period_end;
endmodule

// File: rtl/adv_ret_clkdiv_chk.sv
module adv_ret_clkdiv_chk #(
    parameter int NOM_DIV = 10
) (
    input logic clk,
    input logic rst,
    input logic rate_pulse,
    input logic dir_adv,
    input logic scan,
    input logic code_en
);
    localparam int GW = $clog2(NOM_DIV + 2) + 1;

    logic          seen_q;
    logic [GW-1:0] gap_q;
    logic [1:0]    kind_q;   // 0 nominal, 1 advance, 2 retard
    logic          forced_q; // current period lengthened by scan

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q   <= 1'b0;
            gap_q    <= '0;
            kind_q   <= 2'd0;
            forced_q <= 1'b0;
        end else if (code_en) begin
            seen_q   <= 1'b0;
            gap_q    <= '0;
            forced_q <= 1'b0;
            if (seen_q || rate_pulse) begin
                kind_q   <= (scan || !dir_adv) ? 2'd2 : 2'd1;
                forced_q <= scan && dir_adv;
            end else begin
                kind_q <= 2'd0;
            end
        end else begin
            seen_q <= seen_q | rate_pulse;
            gap_q  <= gap_q + 1'b1;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !code_en);

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
        code_en |=> !code_en);

    a_r2_nominal_len: assert property (@(posedge clk) disable iff (rst)
        (code_en && kind_q == 2'd0) |-> (gap_q == GW'(NOM_DIV - 1)));

    a_r3_advance_len: assert property (@(posedge clk) disable iff (rst)
        (code_en && kind_q == 2'd1) |-> (gap_q == GW'(NOM_DIV - 2)));

    a_r4_retard_len: assert property (@(posedge clk) disable iff (rst)
        (code_en && kind_q == 2'd2) |-> (gap_q == GW'(NOM_DIV)));

    a_r5_scan_retard: assert property (@(posedge clk) disable iff (rst)
        (code_en && forced_q) |-> (gap_q == GW'(NOM_DIV)));
endmodule

bind adv_ret_clkdiv adv_ret_clkdiv_chk #(.NOM_DIV(NOM_DIV)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rate_pulse (rate_pulse),
    .dir_adv    (dir_adv),
    .scan       (scan),
    .code_en    (code_en)
);

// File: tb/sim_adv_ret_clkdiv.sv
`timescale 1ns/1ps
module sim_adv_ret_clkdiv;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate_pulse = 1'b0;
    logic dir_adv = 1'b1;
    logic scan = 1'b0;
    logic code_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adv_ret_clkdiv #(.NOM_DIV(10)) u0 (
        .clk        (clk),
        .rst        (rst),
        .rate_pulse (rate_pulse),
        .dir_adv    (dir_adv),
        .scan       (scan),
        .code_en    (code_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Start at a falling edge where code_en is high; returns the length of the next period.
    task automatic run_period(input logic [15:0] mask, input int flip_at, output int n);
        n = 0;
        do begin
            rate_pulse = (n < 16) ? mask[n] : 1'b0;
            if (n == flip_at) dir_adv = ~dir_adv;
            @(negedge clk);
            n++;
        end while (!code_en && n < 100);
        rate_pulse = 1'b0;
    endtask

    task automatic expect_period(input logic [15:0] mask, input int flip_at,
                                 input int exp, input string req);
        int n;
        run_period(mask, flip_at, n);
        check(n == exp, req, n, exp);
    endtask

    task automatic t_reset();
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(code_en == 1'b0, "R1 low in reset", int'(code_en), 0);
        rst = 1'b0;
        check(code_en == 1'b0, "R1 low at release", int'(code_en), 0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!code_en && n < 100);
        check(n == 9, "R1 first enable", n, 9);
    endtask

    task automatic t_nominal();
        for (int i = 0; i < 3; i++) expect_period(16'h0, -1, 10, "R2 nominal");
    endtask

    task automatic t_width();
        @(negedge clk);
        check(code_en == 1'b0, "R9 one-cycle enable", int'(code_en), 0);
        while (!code_en) @(negedge clk);
    endtask

    task automatic t_advance();
        dir_adv = 1'b1; scan = 1'b0;
        expect_period(16'h1, -1, 9, "R3 advance");
        expect_period(16'h0, -1, 10, "R3 back to nominal");
    endtask

    task automatic t_retard();
        dir_adv = 1'b0; scan = 1'b0;
        expect_period(16'h1, -1, 11, "R4 retard");
        expect_period(16'h0, -1, 10, "R4 back to nominal");
    endtask

    task automatic t_scan();
        dir_adv = 1'b1; scan = 1'b1;
        expect_period(16'h1, -1, 11, "R5 scan forces retard");
        expect_period(16'h0, -1, 10, "R5 scan without pulse");
        scan = 1'b0;
    endtask

    task automatic t_late_pulse();
        dir_adv = 1'b1;
        expect_period(16'h0020, -1, 10, "R6 pulse not applied to current period");
        expect_period(16'h0, -1, 9, "R6 pulse applied to next period");
        expect_period(16'h0, -1, 10, "R6 single use");
    endtask

    task automatic t_multi();
        dir_adv = 1'b1;
        expect_period(16'h004A, -1, 10, "R7 period with several pulses");
        expect_period(16'h0, -1, 9, "R7 one correction");
        expect_period(16'h0, -1, 10, "R7 no second correction");
    endtask

    task automatic t_dir_hold();
        dir_adv = 1'b1; scan = 1'b0;
        expect_period(16'h1, 2, 9, "R8 direction held after load");
        check(dir_adv == 1'b0, "R8 direction did change", int'(dir_adv), 0);
        scan = 1'b0; dir_adv = 1'b0;
        rate_pulse = 1'b1;
        @(negedge clk);
        rate_pulse = 1'b0;
        scan = 1'b1;
        begin
            int n;
            n = 1;
            while (!code_en && n < 100) begin
                @(negedge clk);
                n++;
            end
            check(n == 11, "R8 scan change mid period ignored", n, 11);
        end
        scan = 1'b0;
        dir_adv = 1'b1;
    endtask

    task automatic t_gain();
        dir_adv = 1'b1;
        for (int i = 0; i < 4; i++) expect_period(16'h1, -1, 9, "R10 back-to-back advance");
        expect_period(16'h0, -1, 10, "R10 returns to nominal");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_nominal();
        t_width();
        t_advance();
        t_retard();
        t_scan();
        t_late_pulse();
        t_multi();
        t_dir_hold();
        t_gain();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end
endmodule